// File: doc/BRIEF.md
# Depth-First Itemset Search Controller

This block sequences the candidate search of frequent itemset mining for a single top-level item. Given a root item and the number of items, it walks every candidate itemset that starts with the root in depth-first, lexicographic order. For each candidate it issues one step command to an external support-counting datapath. The datapath ANDs a left operand vector with one single-item right operand vector and counts the ones. It then answers whether the candidate is frequent.

The left operand comes from one of three places: the root's own source vector, the result of the step just completed, or an intermediate result written out earlier. A frequent candidate that can still grow becomes the prefix for the next, deeper step. An infrequent candidate, a leaf, or a candidate that would overflow the stack ends its branch. In that case the controller pulses a flush and moves on to the next sibling or backtracks. Intermediate results are written out only when a later sibling branch will reload them. An on-chip stack holds the last item appended at each depth. Its depth bounds the largest itemset the controller will build.

Top module: `dfs_itemset_ctrl`

## Requirements
- R1: After reset the controller is idle: `cmd_valid`, `busy`, `done`, `err`, `wr_en`, `flush` and `hit` are all low.
- R2: Items are numbered 0 to `start_count`-1. Each command names a candidate made of the current prefix plus one right item (`cmd_ritem`) higher than the last prefix item. `cmd_size` gives the candidate's item count. The candidates are issued in lexicographic order of their sorted item lists, which is depth-first order.
- R3: After a frequent candidate that was descended into, the next command uses the previous result as its left operand (`cmd_lsel` = 1).
- R4: A command that starts a new branch under a prefix of two or more items reloads the stored intermediate (`cmd_lsel` = 2), with `cmd_lslot` equal to the prefix length. Under the root alone it uses the source vector of item `cmd_litem` = root (`cmd_lsel` = 0).
- R5: An infrequent candidate generates no children, is not written out, and is followed by a one-cycle `flush` pulse.
- R6: A frequent candidate with no higher item left (a leaf) is followed by a `flush` pulse and no write.
- R7: The controller descends into a candidate that is frequent, has a higher item left and holds fewer than DEPTH items. For such a candidate, `wr_en` pulses with `wr_slot` = `cmd_size` exactly when at least two higher items remain (right item ≤ `start_count`-3).
- R8: `hit` pulses once, one cycle after the response, for every candidate reported frequent.
- R9: A frequent candidate of DEPTH items that still has a higher item is not descended into. It sets `err`, which stays high until the next start, and is followed by a flush.
- R10: `done` pulses for one cycle after the final response of the search. If root+1 ≥ `start_count`, it pulses in the cycle after the start and no command is issued.
- R11: A command stays asserted and unchanged until `rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; accepted only while idle |
| start_root | input | IW | Root item of the search |
| start_count | input | IW+1 | Number of items in the database |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the search ends |
| err | output | 1 | Stack depth exceeded during this search |
| cmd_valid | output | 1 | Step command valid |
| cmd_lsel | output | 2 | Left operand: 0 source vector, 1 previous result, 2 reloaded intermediate |
| cmd_litem | output | IW | Source item for the left operand (the root) |
| cmd_lslot | output | clog2(DEPTH+1) | Intermediate slot to reload (prefix length) |
| cmd_ritem | output | IW | Right operand item |
| cmd_size | output | clog2(DEPTH+1) | Item count of the candidate |
| rsp_valid | input | 1 | Datapath response for the current command |
| rsp_freq | input | 1 | Candidate support reached the threshold |
| wr_en | output | 1 | Write the last result out as an intermediate |
| wr_slot | output | clog2(DEPTH+1) | Slot for the written intermediate |
| flush | output | 1 | Discard the held result; the branch ended |
| hit | output | 1 | Last candidate was frequent |

## Verification
The bench works on small item counts with every root. It uses four transaction sets. An all-ones set makes every candidate frequent, which drives the search to full stack depth and raises the overflow. An all-infrequent set shows that pruning stops every branch at two items. A nested set and a hashed set give mixed outcomes, so pruning, leaves and sibling reloads interleave. The bench's datapath model actually computes each AND from the routed operands and stored slots. A wrong operand choice or a missed write therefore shows up as a wrong support, and not only as a wrong command field.

// File: rtl/dfs_pkg.sv
// Shared types for the depth-first itemset search controller.
package dfs_pkg;
    // Left operand source of a step command.
    typedef enum logic [1:0] {
        LSEL_SRC    = 2'd0,
        LSEL_PREV   = 2'd1,
        LSEL_RELOAD = 2'd2
    } lsel_e;
endpackage

// File: rtl/dfs_stack.sv
// Prefix stack: entry i holds the item at position i of the current prefix.
// Entry 0 is the root. Assumes push and pop never coincide with init.
module dfs_stack #(
    parameter int IW    = 4,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [IW-1:0] init_item,
    input  logic          push,
    input  logic [IW-1:0] push_item,
    input  logic          pop,
    output logic [LW-1:0] len,
    output logic [IW-1:0] top
);
    logic [IW-1:0] stk [DEPTH];

    // Prefix length bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n)    len <= '0;
        else if (init) len <= LW'(1);
        else if (push) len <= len + LW'(1);
        else if (pop)  len <= len - LW'(1);
    end

    // One register per depth level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n)                          stk[g] <= '0;
            else if (init && g == 0)             stk[g] <= init_item;
            else if (push && len == LW'(g))      stk[g] <= push_item;
        end
    end

    // Last item of the current prefix.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (len == LW'(i + 1)) top = stk[i];
    end

    assert_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (len < LW'(DEPTH)));
    assert_pop_keeps_root_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (len > LW'(1)));
endmodule

// File: rtl/dfs_step_eval.sv
// Decision for one answered step: descend, write out, or end the branch.
// Purely combinational; y is the right item, len the prefix length.
module dfs_step_eval #(
    parameter int IW    = 4,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int CW    = IW + 1
) (
    input  logic          freq,
    input  logic [IW-1:0] y,
    input  logic [LW-1:0] len,
    input  logic [CW-1:0] count,
    output logic          push,
    output logic          store,
    output logic          overflow,
    output logic          more_sib
);
    logic [CW-1:0] y_p1, y_p2;
    logic          room;

    // Descend only if a higher item exists and the stack has room.
    always_comb begin
        y_p1     = CW'(y) + CW'(1);
        y_p2     = CW'(y) + CW'(2);
        more_sib = (y_p1 < count);
        room     = (({1'b0, len} + (LW+1)'(1)) < (LW+1)'(DEPTH));
        push     = freq && more_sib && room;
        overflow = freq && more_sib && !room;
        store    = push && (y_p2 < count);
    end
endmodule

// File: rtl/dfs_itemset_ctrl.sv
// Depth-first candidate walker for one root item. Issues one step command
// at a time and holds it until the datapath answers. Assumes the datapath
// keeps the last result and stores it into wr_slot when wr_en pulses.
module dfs_itemset_ctrl
    import dfs_pkg::*;
#(
    parameter int IW    = 4,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [IW-1:0]                start_root,
    input  logic [IW:0]                  start_count,
    output logic                         busy,
    output logic                         done,
    output logic                         err,
    output logic                         cmd_valid,
    output logic [1:0]                   cmd_lsel,
    output logic [IW-1:0]                cmd_litem,
    output logic [$clog2(DEPTH+1)-1:0]   cmd_lslot,
    output logic [IW-1:0]                cmd_ritem,
    output logic [$clog2(DEPTH+1)-1:0]   cmd_size,
    input  logic                         rsp_valid,
    input  logic                         rsp_freq,
    output logic                         wr_en,
    output logic [$clog2(DEPTH+1)-1:0]   wr_slot,
    output logic                         flush,
    output logic                         hit
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int CW = IW + 1;

    logic          busy_q, done_q, err_q, wr_q, flush_q, hit_q;
    logic [LW-1:0] wslot_q;
    logic [IW-1:0] root_q, y_q;
    logic [CW-1:0] count_q;
    lsel_e         mode_q;

    logic          accept, st_init, st_push, st_pop;
    logic          ev_push, ev_store, ev_ovf, ev_more;
    logic [LW-1:0] len;
    logic [IW-1:0] top;

    dfs_stack #(.IW(IW), .DEPTH(DEPTH), .LW(LW)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .init(st_init), .init_item(start_root),
        .push(st_push), .push_item(y_q),
        .pop(st_pop), .len(len), .top(top)
    );

    dfs_step_eval #(.IW(IW), .DEPTH(DEPTH), .LW(LW), .CW(CW)) u_eval (
        .freq(rsp_freq), .y(y_q), .len(len), .count(count_q),
        .push(ev_push), .store(ev_store), .overflow(ev_ovf), .more_sib(ev_more)
    );

    // Stack control from the handshake and the step decision.
    always_comb begin
        accept  = busy_q && rsp_valid;
        st_init = start && !busy_q;
        st_push = accept && ev_push;
        st_pop  = accept && !ev_push && !ev_more && (len > LW'(1));
    end

    // Search state: next right item, operand source, flags and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            wr_q    <= 1'b0;
            flush_q <= 1'b0;
            hit_q   <= 1'b0;
            wslot_q <= '0;
            root_q  <= '0;
            y_q     <= '0;
            count_q <= '0;
            mode_q  <= LSEL_SRC;
        end else begin
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            flush_q <= 1'b0;
            hit_q   <= 1'b0;
            if (st_init) begin
                root_q  <= start_root;
                count_q <= start_count;
                err_q   <= 1'b0;
                y_q     <= start_root + IW'(1);
                mode_q  <= LSEL_SRC;
                if ((CW'(start_root) + CW'(1)) < start_count) busy_q <= 1'b1;
                else                                          done_q <= 1'b1;
            end else if (accept) begin
                hit_q   <= rsp_freq;
                wr_q    <= ev_store;
                wslot_q <= len + LW'(1);
                flush_q <= !ev_push;
                if (ev_ovf) err_q <= 1'b1;
                if (ev_push) begin
                    y_q    <= y_q + IW'(1);
                    mode_q <= LSEL_PREV;
                end else if (ev_more) begin
                    y_q    <= y_q + IW'(1);
                    mode_q <= (len == LW'(1)) ? LSEL_SRC : LSEL_RELOAD;
                end else if (len > LW'(1)) begin
                    y_q    <= top + IW'(1);
                    mode_q <= (len == LW'(2)) ? LSEL_SRC : LSEL_RELOAD;
                end else begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Port mapping of the held command and pulses.
    always_comb begin
        busy      = busy_q;
        done      = done_q;
        err       = err_q;
        cmd_valid = busy_q;
        cmd_lsel  = mode_q;
        cmd_litem = root_q;
        cmd_lslot = len;
        cmd_ritem = y_q;
        cmd_size  = len + LW'(1);
        wr_en     = wr_q;
        wr_slot   = wslot_q;
        flush     = flush_q;
        hit       = hit_q;
    end

    assert_hold_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_ritem) && $stable(cmd_lsel)));
    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ritem > top));
    assert_reload_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_lsel == 2'd2) |-> (cmd_lslot >= LW'(2)));
    assert_store_not_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !flush);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);
endmodule

// File: tb/dfs_itemset_ctrl_tb.sv
module dfs_itemset_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 4;
    localparam int DEPTH = 4;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IW-1:0] start_root = '0;
    logic [IW:0]   start_count = '0;
    logic busy, done, err, cmd_valid, rsp_valid = 1'b0, rsp_freq = 1'b0;
    logic [1:0] cmd_lsel;
    logic [IW-1:0] cmd_litem, cmd_ritem;
    logic [LW-1:0] cmd_lslot, cmd_size, wr_slot;
    logic wr_en, flush, hit;

    dfs_itemset_ctrl #(.IW(IW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_root(start_root),
        .start_count(start_count), .busy(busy), .done(done), .err(err),
        .cmd_valid(cmd_valid), .cmd_lsel(cmd_lsel), .cmd_litem(cmd_litem),
        .cmd_lslot(cmd_lslot), .cmd_ritem(cmd_ritem), .cmd_size(cmd_size),
        .rsp_valid(rsp_valid), .rsp_freq(rsp_freq), .wr_en(wr_en),
        .wr_slot(wr_slot), .flush(flush), .hit(hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    bit timeout = 0;
    logic [7:0] vec [8];
    logic [7:0] slot_mem [8];
    int thr;
    int exp_mask [64];
    int exp_n;

    initial begin
        repeat (150000) @(posedge clk);
        timeout = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int pc(input int m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += (m >> i) & 1;
        return c;
    endfunction

    function automatic int support(input int m);
        logic [7:0] a = 8'hFF;
        for (int i = 0; i < 8; i++) if (((m >> i) & 1) == 1) a &= vec[i];
        return pc(int'(a));
    endfunction

    function automatic int hibit(input int m);
        int h = 0;
        for (int i = 0; i < 8; i++) if (((m >> i) & 1) == 1) h = i;
        return h;
    endfunction

    // Lexicographic order of sorted item lists.
    function automatic bit lex_less(input int a, input int b);
        for (int i = 0; i < 8; i++) begin
            int ai = (a >> i) & 1;
            int bi = (b >> i) & 1;
            if (ai != bi) begin
                if (ai == 1) return ((b >> i) != 0);
                else         return ((a >> i) == 0);
            end
        end
        return 0;
    endfunction

    task automatic build_list(input int n, input int root);
        exp_n = 0;
        for (int m = 0; m < (1 << n); m++) begin
            bit ok = (((m >> root) & 1) == 1) && ((m & ((1 << root) - 1)) == 0)
                     && pc(m) >= 2 && pc(m) <= DEPTH;
            if (ok) begin
                int pre = 0;
                int cnt = 0;
                for (int i = 0; i < n; i++) begin
                    if (((m >> i) & 1) == 1) begin
                        cnt++;
                        pre |= (1 << i);
                        if (cnt >= 2 && cnt < pc(m) && support(pre) < thr) ok = 0;
                    end
                end
            end
            if (ok) begin
                exp_mask[exp_n] = m;
                exp_n++;
            end
        end
        for (int i = 0; i < exp_n; i++)
            for (int j = i + 1; j < exp_n; j++)
                if (lex_less(exp_mask[j], exp_mask[i])) begin
                    int t = exp_mask[i];
                    exp_mask[i] = exp_mask[j];
                    exp_mask[j] = t;
                end
    endtask

    task automatic run_case(input int n, input int root, input int ds);
        int k = 0, hits = 0, exp_hits = 0, guard = 0;
        bit exp_err = 0, seen_done = 0, pend = 0, prev_push = 0;
        bit p_store = 0, p_flush = 0, p_hit = 0;
        int p_slot = 0;
        logic [7:0] last_res = '0;
        for (int i = 0; i < 8; i++) begin
            case (ds)
                0: vec[i] = 8'hFF;
                1: vec[i] = 8'hFF << i;
                2: vec[i] = 8'(i * 53 + 29) ^ (8'h5A >> i);
                default: vec[i] = 8'hFF;
            endcase
            slot_mem[i] = '0;
        end
        thr = (ds == 0) ? 1 : (ds == 1) ? 3 : (ds == 2) ? 2 : 9;
        build_list(n, root);
        @(negedge clk);
        start = 1'b1; start_root = IW'(root); start_count = (IW+1)'(n);
        @(negedge clk);
        start = 1'b0;
        while (!timeout && guard < 500) begin
            guard++;
            if (pend) begin
                chk(wr_en == p_store, "R7 write-out", int'(wr_en), int'(p_store));
                if (p_store) chk(wr_slot == LW'(p_slot), "R7 slot", int'(wr_slot), p_slot);
                chk(flush == p_flush, "R5/R6 flush", int'(flush), int'(p_flush));
                chk(hit == p_hit, "R8 hit", int'(hit), int'(p_hit));
                if (wr_en) slot_mem[wr_slot] = last_res;
                if (hit) hits++;
                pend = 0;
            end
            if (done) begin
                seen_done = 1;
                break;
            end
            if (cmd_valid) begin
                int m, sz, ri, sup;
                bit fr, more, psh;
                logic [7:0] left;
                if (k >= exp_n) begin
                    chk(0, "R2 extra command", k, exp_n);
                    break;
                end
                m = exp_mask[k];
                sz = pc(m);
                ri = hibit(m);
                chk(cmd_ritem == IW'(ri), "R2 right item", int'(cmd_ritem), ri);
                chk(cmd_size == LW'(sz), "R2 size", int'(cmd_size), sz);
                if (prev_push)
                    chk(cmd_lsel == 2'd1, "R3 previous result", int'(cmd_lsel), 1);
                else if (sz == 2) begin
                    chk(cmd_lsel == 2'd0, "R4 source", int'(cmd_lsel), 0);
                    chk(cmd_litem == IW'(root), "R4 root item", int'(cmd_litem), root);
                end else begin
                    chk(cmd_lsel == 2'd2, "R4 reload", int'(cmd_lsel), 2);
                    chk(cmd_lslot == LW'(sz - 1), "R4 slot", int'(cmd_lslot), sz - 1);
                end
                case (cmd_lsel)
                    2'd0: left = vec[cmd_litem];
                    2'd1: left = last_res;
                    default: left = slot_mem[cmd_lslot];
                endcase
                last_res = left & vec[cmd_ritem];
                sup = pc(int'(last_res));
                chk(sup == support(m), "R2/R4 operand support", sup, support(m));
                if ((k % 3) == 2) begin
                    @(negedge clk);
                    chk(cmd_valid && cmd_ritem == IW'(ri) && cmd_size == LW'(sz),
                        "R11 held command", int'(cmd_ritem), ri);
                end
                fr = (support(m) >= thr);
                more = (ri < n - 1);
                psh = fr && more && (sz < DEPTH);
                if (fr) exp_hits++;
                if (fr && more && sz == DEPTH) exp_err = 1;
                p_store = psh && (ri <= n - 3);
                p_slot = sz;
                p_flush = !psh;
                p_hit = fr;
                prev_push = psh;
                rsp_valid = 1'b1;
                rsp_freq = (sup >= thr);
                @(negedge clk);
                rsp_valid = 1'b0;
                pend = 1;
                k++;
            end else begin
                @(negedge clk);
            end
        end
        chk(seen_done, "R10 done pulse", int'(seen_done), 1);
        chk(k == exp_n, "R2 command count", k, exp_n);
        chk(hits == exp_hits, "R8 hit count", hits, exp_hits);
        chk(err == exp_err, "R9 overflow flag", int'(err), int'(exp_err));
        @(negedge clk);
        chk(!done && !cmd_valid, "R10 single done", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!cmd_valid && !busy && !done && !err, "R1 reset idle", int'(busy), 0);
        chk(!wr_en && !flush && !hit, "R1 reset pulses", int'(flush), 0);
        rst_n = 1'b1;
        for (int ds = 0; ds < 4; ds++)
            for (int n = 2; n <= 6; n++)
                for (int r = 0; r < n; r++)
                    if (!timeout) run_case(n, r, ds);
        if (timeout) chk(0, "watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule